// File: doc/BRIEF.md
# Width-Selectable Parallel-to-Serial Transmitter

This block turns a parallel data word into a serial bit stream, one bit per bit-clock cycle. A word-rate reference clock is sampled in the bit-clock domain. On each of its rising edges, the data word present at the inputs is copied into a hold register. A static width select chooses the word size. When the select is low, all twenty data inputs form the word. When it is high, only the upper ten inputs are used.

A two-state machine controls the shifter. In `ST_IDLE` no word is held and both serial outputs stay low. The transition IDLE->SEND happens on the first bit-clock edge that finds a captured word: the shifter loads that word and the bit counter clears. In `ST_SEND` the shifter moves one bit per cycle. The transition SEND->SEND (reload) happens when the counter reaches the last bit of the active width: the shifter reloads from the hold register, so words follow each other with no gap. The transition any->IDLE happens on a rising edge of the width select. It clears the machine, the hold register and the word clock. A word-rate clock output and its complement flip at every load. The bit stream drives two outputs: a main output and a loopback output. Each has its own enable.

Top module: `widesel_serializer`

## Requirements
- R1: The data word is captured at the bit-clock edge where `ref_wclk` is first seen high after being low; later changes of `pdata` do not alter the word being sent.
- R2: With `width_sel` low, a word is sent as `pdata[0]` first through `pdata[19]` last, one bit per bit-clock cycle.
- R3: With `width_sel` high, a word is sent as `pdata[10]` first through `pdata[19]` last, and `pdata[9:0]` have no effect on the stream.
- R4: A serial output whose enable is low is held low.
- R5: `ser_loop` carries the same bit stream as `ser_main`, gated by its own enable `oe_loop`.
- R6: On the bit-clock edge where `width_sel` is first seen high, the block returns to idle. The captured word is discarded, both serial outputs and `wclk_out` go low, and they stay low until a new word is captured.
- R7: `wclk_out` flips on the same edge at which the first bit of each word is presented, and `wclk_out_n` is always its inverse.
- R8: After a reset, both serial outputs stay low until a word is captured. The first bit of that word appears on the bit-clock edge that follows the capture edge.
- R9: Consecutive words, each captured once per word period, leave the serial outputs with no idle bit between them in either width.
- R10: While `rst_n` is low, both serial outputs and `wclk_out` are low and `wclk_out_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_wclk | input | 1 | Word-rate reference clock, sampled by clk_bit |
| width_sel | input | 1 | Low: 20-bit words; high: 10-bit words; a rising edge resets |
| pdata | input | 20 | Parallel data word |
| oe_main | input | 1 | Enable of the main serial output |
| oe_loop | input | 1 | Enable of the loopback serial output |
| ser_main | output | 1 | Main serial output |
| ser_loop | output | 1 | Loopback serial output |
| wclk_out | output | 1 | Word-rate clock output |
| wclk_out_n | output | 1 | Complement of wclk_out |

## Verification
The stream is driven with asymmetric 20-bit words, all-ones and all-zeros words, and single-bit words with the bit at either end. A word that came out reversed or shifted by one bit would not match any of these. In 10-bit mode the lower half of the bus carries busy values that differ from word to word, so any leak of ignored inputs would show up in the stream. The enables are switched between words, one at a time and both together. This tells a missing gate apart from a swapped one. A width-select rising edge in the middle of a stream checks that the block returns to idle rather than finishing the word it was sending.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1
    } tx_state_e;

endpackage

// File: rtl/sertx_rise_detect.sv
module sertx_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;

endmodule

// File: rtl/sertx_capture.sv
module sertx_capture #(
    parameter int WIDE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              narrow,
    input  logic [WIDE_W-1:0] din,
    output logic [WIDE_W-1:0] word,
    output logic              valid
);

    localparam int HALF_W = WIDE_W / 2;

    logic [WIDE_W-1:0] lane;

    // Narrow mode moves the upper half down to bit 0 so that it is sent first.
    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        if (i < HALF_W) begin : g_low
            assign lane[i] = narrow ? din[i+HALF_W] : din[i];
        end else begin : g_high
            assign lane[i] = narrow ? 1'b0 : din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (clr) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (take) begin
            word  <= lane;
            valid <= 1'b1;
        end
    end

    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);

    p_narrow_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && narrow && !clr) |=> (word[WIDE_W-1:HALF_W] == '0));

endmodule

// File: rtl/sertx_shift_fsm.sv
module sertx_shift_fsm
    import sertx_pkg::*;
#(
    parameter int WIDE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              narrow,
    input  logic [WIDE_W-1:0] word,
    input  logic              valid,
    output logic              bit_o,
    output logic              active,
    output logic              load
);

    localparam int HALF_W = WIDE_W / 2;
    localparam int CW     = $clog2(WIDE_W);

    tx_state_e         state, state_nx;
    logic [WIDE_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     last;
    logic              at_end;

    assign last   = narrow ? CW'(HALF_W - 1) : CW'(WIDE_W - 1);
    assign at_end = (cnt == last);

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (valid) begin
                    load     = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (at_end) load = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load) begin
            shreg <= word;
            cnt   <= '0;
        end else if (state == ST_SEND) begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
        end
    end

    assign active = (state == ST_SEND);
    assign bit_o  = active & shreg[0];

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        active |-> (cnt <= last));

    p_reload_restart_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
        load |=> (active && cnt == '0));

endmodule

// File: rtl/sertx_out_stage.sv
module sertx_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic bit_i,
    input  logic oe_main,
    input  logic oe_loop,
    output logic ser_main,
    output logic ser_loop,
    output logic wclk,
    output logic wclk_n
);

    logic wtog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wtog <= 1'b0;
        else if (clr)  wtog <= 1'b0;
        else if (load) wtog <= ~wtog;
    end

    assign wclk     = wtog;
    assign wclk_n   = ~wtog;
    assign ser_main = oe_main & bit_i;
    assign ser_loop = oe_loop & bit_i;

    p_wclk_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (wclk != $past(wclk)));

    p_wclk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(wclk));

endmodule

// File: rtl/widesel_serializer.sv
module widesel_serializer #(
    parameter int WIDE_W = 20
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              ref_wclk,
    input  logic              width_sel,
    input  logic [WIDE_W-1:0] pdata,
    input  logic              oe_main,
    input  logic              oe_loop,
    output logic              ser_main,
    output logic              ser_loop,
    output logic              wclk_out,
    output logic              wclk_out_n
);

    logic ref_rise;
    logic sel_rise;
    logic [WIDE_W-1:0] held;
    logic held_ok;
    logic bit_s;
    logic act_s;
    logic load_s;

    sertx_rise_detect u_ref_edge (
        .clk(clk_bit), .rst_n(rst_n), .sig_in(ref_wclk), .rise(ref_rise)
    );

    sertx_rise_detect u_sel_edge (
        .clk(clk_bit), .rst_n(rst_n), .sig_in(width_sel), .rise(sel_rise)
    );

    sertx_capture #(.WIDE_W(WIDE_W)) u_cap (
        .clk(clk_bit), .rst_n(rst_n), .clr(sel_rise), .take(ref_rise),
        .narrow(width_sel), .din(pdata), .word(held), .valid(held_ok)
    );

    sertx_shift_fsm #(.WIDE_W(WIDE_W)) u_fsm (
        .clk(clk_bit), .rst_n(rst_n), .clr(sel_rise), .narrow(width_sel),
        .word(held), .valid(held_ok), .bit_o(bit_s), .active(act_s), .load(load_s)
    );

    sertx_out_stage u_out (
        .clk(clk_bit), .rst_n(rst_n), .clr(sel_rise), .load(load_s), .bit_i(bit_s),
        .oe_main(oe_main), .oe_loop(oe_loop), .ser_main(ser_main),
        .ser_loop(ser_loop), .wclk(wclk_out), .wclk_n(wclk_out_n)
    );

    p_off_low_r4: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !oe_main |-> !ser_main);

    p_loop_same_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (oe_main && oe_loop) |-> (ser_main == ser_loop));

    p_sel_rise_idle_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(width_sel) |=> (!ser_main && !ser_loop && !wclk_out));

    p_idle_quiet_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !act_s |-> (!ser_main && !ser_loop));

endmodule

// File: tb/widesel_serializer_test.sv
module widesel_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n, ref_wclk, width_sel, oe_main, oe_loop;
    logic [19:0] pdata;
    logic        ser_main, ser_loop, wclk_out, wclk_out_n;

    always #10 clk = ~clk;

    widesel_serializer uut (
        .clk_bit(clk), .rst_n(rst_n), .ref_wclk(ref_wclk), .width_sel(width_sel),
        .pdata(pdata), .oe_main(oe_main), .oe_loop(oe_loop), .ser_main(ser_main),
        .ser_loop(ser_loop), .wclk_out(wclk_out), .wclk_out_n(wclk_out_n)
    );

    typedef struct packed { logic b; logic first; } exp_t;
    exp_t  exp_q[$];
    int    skip = 0;
    bit    mon_en = 0;
    logic  exp_wclk = 1'b0;
    string cur_req = "R2";
    int    n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Scoreboard monitor: samples on the falling edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (skip > 0) begin
                skip--;
                check(ser_main == 1'b0 && ser_loop == 1'b0, "R8", "quiet before first bit",
                      int'(ser_main) + int'(ser_loop), 0);
            end else if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.first) exp_wclk = ~exp_wclk;
                check(ser_main === (e.b & oe_main), oe_main ? cur_req : "R4", "ser_main",
                      int'(ser_main), int'(e.b & oe_main));
                check(ser_loop === (e.b & oe_loop), "R5", "ser_loop",
                      int'(ser_loop), int'(e.b & oe_loop));
                check(wclk_out === exp_wclk && wclk_out_n === ~exp_wclk, "R7", "word clock",
                      int'(wclk_out), int'(exp_wclk));
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic send_word(input logic [19:0] w, input bit first_after_idle);
        int n;
        n = width_sel ? 10 : 20;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.b     = width_sel ? w[10+i] : w[i];
            e.first = (i == 0);
            exp_q.push_back(e);
        end
        if (first_after_idle) begin
            skip   = 2;
            mon_en = 1;
        end
        pdata    = w;
        ref_wclk = 1'b1;
        step();
        pdata = ~w;                       // R1: change after capture must not matter
        for (int i = 1; i < n / 2; i++) step();
        ref_wclk = 1'b0;
        for (int i = 0; i < n - n / 2; i++) step();
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        step();
        mon_en = 0;
    endtask

    task automatic hard_reset();
        mon_en = 0;
        exp_q.delete();
        skip  = 0;
        rst_n = 1'b0;
        step();
        check(ser_main == 0 && ser_loop == 0, "R10", "serial in reset",
              int'(ser_main) + int'(ser_loop), 0);
        check(wclk_out == 0 && wclk_out_n == 1, "R10", "word clock in reset",
              int'(wclk_out), 0);
        step();
        rst_n    = 1'b1;
        exp_wclk = 1'b0;
        step();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; ref_wclk = 1'b0; width_sel = 1'b0; pdata = '0;
        oe_main = 1'b1; oe_loop = 1'b1;
        hard_reset();

        // R8: nothing leaves before a capture
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(ser_main == 0 && ser_loop == 0 && wclk_out == 0, "R8", "idle after reset",
                  int'(ser_main), 0);
        end
        step();

        // R1 R2 R9: 20-bit back-to-back stream
        cur_req = "R1 R2 R9";
        send_word(20'hABCDE, 1);
        send_word(20'h12345, 0);
        send_word(20'hFFFFF, 0);
        send_word(20'h00000, 0);
        send_word(20'h00001, 0);
        send_word(20'h80000, 0);
        drain();

        // R4 R5: enables switched between words
        hard_reset();
        cur_req = "R2";
        oe_main = 1'b0; oe_loop = 1'b1;
        send_word(20'h5A5A5, 1);
        oe_main = 1'b1; oe_loop = 1'b0;
        send_word(20'hC3C3C, 0);
        oe_main = 1'b0; oe_loop = 1'b0;
        send_word(20'hFFFFF, 0);
        oe_main = 1'b1; oe_loop = 1'b1;
        send_word(20'h0F0F0, 0);
        drain();

        // R6: width-select rise in the middle of a stream
        hard_reset();
        send_word(20'hFFFFF, 1);
        mon_en = 0;
        exp_q.delete();
        skip = 0;
        step();
        width_sel = 1'b1;
        exp_wclk  = 1'b0;
        step();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ser_main == 0 && ser_loop == 0, "R6", "serial after select rise",
                  int'(ser_main) + int'(ser_loop), 0);
            check(wclk_out == 0, "R6", "word clock after select rise", int'(wclk_out), 0);
        end
        step();

        // R3 R9: 10-bit stream with busy ignored lower inputs
        cur_req = "R3 R9";
        send_word({10'h2B7, 10'h3FF}, 1);
        send_word({10'h001, 10'h155}, 0);
        send_word({10'h200, 10'h2AA}, 0);
        send_word({10'h3FF, 10'h000}, 0);
        send_word({10'h000, 10'h3FF}, 0);
        send_word({10'h155, 10'h0F3}, 0);
        drain();

        // Back to 20-bit after a reset
        width_sel = 1'b0;
        hard_reset();
        cur_req = "R2 R8";
        send_word(20'h6B1E9, 1);
        send_word(20'h94E16, 0);
        drain();

        finish_up();
    end

endmodule